// File: doc/BRIEF.md
# Output Port Register with Flow-Control Pin Muxing

This block drives an eight-bit general output port. A stored port register changes only through two masked commands on a small command/data bus. One command sets every bit flagged by a one in the data word. The other clears every bit flagged that way. Bits whose data position holds a zero keep their value.

Each pin then picks its source. Pins 2 to 7 each have a select bit: the pin follows either the inverted register bit or an internal signal. Pins 0 and 1 can carry three things:
- the inverted register bit;
- an active-low request-to-send, formed as the NAND of the register bit and the receiver's live request;
- an active-low transmitter-done flag.

The request-to-send path needs the register bit set before the request can appear. Turning flow control on or off never alters the stored bit.

The block has no state machine. The register is a single always_ff with two named update transitions, SET (code 0xE) and CLEAR (code 0xF). Every other command leaves the register unchanged.

Top module: `opr_port_top`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, the register holds all zeros. With register sources selected, every pin reads 1.
- R2: A valid command with code 0xE sets each register bit whose `cmd_data` position is 1. All other bits are unchanged. The new value shows on the pins one clock edge after the command.
- R3: A valid command with code 0xF clears each register bit whose `cmd_data` position is 1. All other bits are unchanged.
- R4: A command with any other code, or with `cmd_valid` low, leaves the register unchanged.
- R5: A pin sourced from the register reads the inverse of its register bit.
- R6: For pin k, with k from 2 to 7, `hi_src_sel[k-2]`=1 makes the pin equal `hi_alt[k-2]`. A value of 0 selects the register.
- R7: For pin j, with j in {0,1}, `rts_ctl_en[j]`=1 and `txd_ctl_en[j]`=0 make the pin equal NOT(register bit j AND `rx_rts[j]`).
- R8: Enabling or disabling request-to-send control leaves the stored bit unchanged. Once it is disabled, the pin is again the inverted register bit.
- R9: For pin j, with j in {0,1}, `txd_ctl_en[j]`=1 and `rts_ctl_en[j]`=0 make the pin equal NOT `tx_done[j]`. The register bit has no effect.
- R10: When both controls are enabled on pin j, the pin is low if either the request-to-send term or `tx_done[j]` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code: 0xE sets bits, 0xF clears bits |
| cmd_data | input | 8 | Bit mask for the command |
| hi_src_sel | input | 6 | Per-pin source select for pins 2..7 (1 = internal signal) |
| hi_alt | input | 6 | Internal signals for pins 2..7 |
| rts_ctl_en | input | 2 | Receiver request-to-send control enable for pins 0,1 |
| rx_rts | input | 2 | Live receiver request, active high |
| txd_ctl_en | input | 2 | Transmitter-done control enable for pins 0,1 |
| tx_done | input | 2 | Transmitter finished its last byte, active high |
| port_pins | output | 8 | Pin levels |

## Verification
The hardest case to reach from the ports is R8. It requires showing that the stored bit survives a flow-control enable and disable while that bit is invisible behind the NAND. The stimulus first sets the bit and holds `rx_rts` low, so the pin stays high under flow control even though the bit is 1. It then disables flow control without issuing any command, and the pin must drop low, which proves the bit was kept. The mixed case of R10 is covered by walking `rx_rts` and `tx_done` through all four combinations with both enables on.

// File: rtl/opr_pkg.sv
package opr_pkg;
    localparam int unsigned CMD_W = 4;
    localparam logic [CMD_W-1:0] OPC_SET_BITS = 4'hE;
    localparam logic [CMD_W-1:0] OPC_CLR_BITS = 4'hF;
endpackage

// File: rtl/opr_cmd_reg.sv
module opr_cmd_reg
    import opr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic [W-1:0]     cmd_data,
    output logic [W-1:0]     opr_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opr_q <= '0;
        end else if (cmd_valid) begin
            unique case (cmd_code)
                OPC_SET_BITS: opr_q <= opr_q | cmd_data;
                OPC_CLR_BITS: opr_q <= opr_q & ~cmd_data;
                default:      opr_q <= opr_q;
            endcase
        end
    end
endmodule

// File: rtl/opr_pin_lo.sv
module opr_pin_lo (
    input  logic reg_bit,
    input  logic rts_en,
    input  logic rts_req,
    input  logic txd_en,
    input  logic txd_flag,
    output logic pin
);
    logic rts_term;
    logic reg_term;
    logic active;

    always_comb begin
        rts_term = rts_en & reg_bit & rts_req;
        reg_term = ~rts_en & ~txd_en & reg_bit;
        active   = rts_term | reg_term | (txd_en & txd_flag);
        pin      = ~active;
    end
endmodule

// File: rtl/opr_pin_hi.sv
module opr_pin_hi (
    input  logic reg_bit,
    input  logic alt_sel,
    input  logic alt_sig,
    output logic pin
);
    always_comb begin
        pin = alt_sel ? alt_sig : ~reg_bit;
    end
endmodule

// File: rtl/opr_port_top.sv
module opr_port_top
    import opr_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned N_LO = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic [W-1:0]     cmd_data,
    input  logic [W-N_LO-1:0] hi_src_sel,
    input  logic [W-N_LO-1:0] hi_alt,
    input  logic [N_LO-1:0]  rts_ctl_en,
    input  logic [N_LO-1:0]  rx_rts,
    input  logic [N_LO-1:0]  txd_ctl_en,
    input  logic [N_LO-1:0]  tx_done,
    output logic [W-1:0]     port_pins
);
    localparam int unsigned N_HI = W - N_LO;

    logic [W-1:0] opr_q;

    opr_cmd_reg #(.W(W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_data  (cmd_data),
        .opr_q     (opr_q)
    );

    for (genvar j = 0; j < N_LO; j++) begin : g_lo
        opr_pin_lo u_lo (
            .reg_bit  (opr_q[j]),
            .rts_en   (rts_ctl_en[j]),
            .rts_req  (rx_rts[j]),
            .txd_en   (txd_ctl_en[j]),
            .txd_flag (tx_done[j]),
            .pin      (port_pins[j])
        );
    end

    for (genvar k = 0; k < N_HI; k++) begin : g_hi
        opr_pin_hi u_hi (
            .reg_bit (opr_q[N_LO+k]),
            .alt_sel (hi_src_sel[k]),
            .alt_sig (hi_alt[k]),
            .pin     (port_pins[N_LO+k])
        );
    end
endmodule

// File: rtl/opr_port_chk.sv
module opr_port_chk
    import opr_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned N_LO = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [CMD_W-1:0] cmd_code,
    input logic [W-1:0]     cmd_data,
    input logic [W-N_LO-1:0] hi_src_sel,
    input logic [W-N_LO-1:0] hi_alt,
    input logic [N_LO-1:0]  rts_ctl_en,
    input logic [N_LO-1:0]  rx_rts,
    input logic [N_LO-1:0]  txd_ctl_en,
    input logic [N_LO-1:0]  tx_done,
    input logic [W-1:0]     opr_q,
    input logic [W-1:0]     port_pins
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (opr_q == '0)); // R1

    AST_SET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OPC_SET_BITS) |=>
        (opr_q == ($past(opr_q) | $past(cmd_data)))); // R2

    AST_CLR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OPC_CLR_BITS) |=>
        (opr_q == ($past(opr_q) & ~$past(cmd_data)))); // R3

    AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || (cmd_code != OPC_SET_BITS && cmd_code != OPC_CLR_BITS))
        |=> $stable(opr_q)); // R4

    AST_HI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        port_pins[W-1:N_LO] == ((hi_src_sel & hi_alt) | (~hi_src_sel & ~opr_q[W-1:N_LO]))); // R6

    AST_PIN0_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_ctl_en[0] && !txd_ctl_en[0]) |-> (port_pins[0] == !(opr_q[0] && rx_rts[0]))); // R7

    AST_PIN0_TXD: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_ctl_en[0] && !rts_ctl_en[0]) |-> (port_pins[0] == !tx_done[0])); // R9

    AST_PIN0_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!txd_ctl_en[0] && !rts_ctl_en[0]) |-> (port_pins[0] == !opr_q[0])); // R5
endmodule

bind opr_port_top opr_port_chk #(.W(W), .N_LO(N_LO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_data   (cmd_data),
    .hi_src_sel (hi_src_sel),
    .hi_alt     (hi_alt),
    .rts_ctl_en (rts_ctl_en),
    .rx_rts     (rx_rts),
    .txd_ctl_en (txd_ctl_en),
    .tx_done    (tx_done),
    .opr_q      (opr_q),
    .port_pins  (port_pins)
);

// File: tb/test_opr_port_top.sv
`timescale 1ns/1ps
module test_opr_port_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'h0;
    logic [7:0] cmd_data = 8'h00;
    logic [5:0] hi_src_sel = '0;
    logic [5:0] hi_alt = '0;
    logic [1:0] rts_ctl_en = '0;
    logic [1:0] rx_rts = '0;
    logic [1:0] txd_ctl_en = '0;
    logic [1:0] tx_done = '0;
    logic [7:0] port_pins;

    typedef struct {
        logic [7:0] pins;
        string      req;
    } exp_t;

    exp_t   sb_q[$];
    event   chk_ev;
    int     n_run = 0;
    int     n_fail = 0;
    logic [7:0] model = 8'h00;
    bit     done = 1'b0;

    always #2.5 clk = ~clk;

    opr_port_top i_opr_port_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_data   (cmd_data),
        .hi_src_sel (hi_src_sel),
        .hi_alt     (hi_alt),
        .rts_ctl_en (rts_ctl_en),
        .rx_rts     (rx_rts),
        .txd_ctl_en (txd_ctl_en),
        .tx_done    (tx_done),
        .port_pins  (port_pins)
    );

    function automatic logic [7:0] expect_pins();
        logic [7:0] p;
        for (int k = 2; k < 8; k++)
            p[k] = hi_src_sel[k-2] ? hi_alt[k-2] : ~model[k];
        for (int j = 0; j < 2; j++) begin
            logic act;
            act = 1'b0;
            if (rts_ctl_en[j]) act = act | (model[j] & rx_rts[j]);
            if (txd_ctl_en[j]) act = act | tx_done[j];
            if (!rts_ctl_en[j] && !txd_ctl_en[j]) act = model[j];
            p[j] = ~act;
        end
        return p;
    endfunction

    // driver: one clock step with optional command, then push expectation
    task automatic step(input logic v, input logic [3:0] c, input logic [7:0] d, input string req);
        exp_t e;
        @(negedge clk);
        cmd_valid = v;
        cmd_code  = c;
        cmd_data  = d;
        @(posedge clk);
        #1;
        if (!rst_n) model = 8'h00;
        else if (v && c == 4'hE) model = model | d;
        else if (v && c == 4'hF) model = model & ~d;
        cmd_valid = 1'b0;
        e.pins = expect_pins();
        e.req  = req;
        sb_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    // monitor
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if (port_pins !== e.pins) begin
                    n_fail++;
                    $display("FAIL %s: pins=%b expected=%b", e.req, port_pins, e.pins);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(1'b0, 4'h0, 8'h00, "R1 reset");
        step(1'b1, 4'hE, 8'hFF, "R1 set ignored in reset");
        rst_n = 1'b1;
        step(1'b0, 4'h0, 8'h00, "R1 idle high");
        step(1'b1, 4'hE, 8'hA5, "R2 set A5 / R5");
        step(1'b1, 4'hE, 8'h0A, "R2 set 0A keeps others");
        step(1'b1, 4'hF, 8'h21, "R3 clear 21");
        step(1'b1, 4'hF, 8'h00, "R3 clear zero mask");
        step(1'b1, 4'h8, 8'hFF, "R4 other code");
        step(1'b0, 4'hE, 8'h50, "R4 valid low");
        step(1'b1, 4'hD, 8'h00, "R4 code D");
        hi_src_sel = 6'b101010; hi_alt = 6'b110011;
        step(1'b0, 4'h0, 8'h00, "R6 mixed select");
        hi_alt = 6'b001100;
        step(1'b0, 4'h0, 8'h00, "R6 alt change");
        hi_src_sel = '0;
        step(1'b1, 4'hF, 8'hFF, "R3 clear all");
        step(1'b1, 4'hE, 8'h03, "R2 set pins 0,1");
        rts_ctl_en = 2'b11; rx_rts = 2'b00;
        step(1'b0, 4'h0, 8'h00, "R7/R8 rts idle, bit hidden");
        rx_rts = 2'b01;
        step(1'b0, 4'h0, 8'h00, "R7 rts pin0 active");
        rx_rts = 2'b10;
        step(1'b0, 4'h0, 8'h00, "R7 rts pin1 active");
        step(1'b1, 4'hF, 8'h02, "R7 bit1 cleared, rts blocked");
        rx_rts = 2'b00;
        step(1'b0, 4'h0, 8'h00, "R8 rts low again");
        rts_ctl_en = 2'b00;
        step(1'b0, 4'h0, 8'h00, "R8 disable restores register view");
        txd_ctl_en = 2'b11; tx_done = 2'b00;
        step(1'b0, 4'h0, 8'h00, "R9 tx not done, register ignored");
        tx_done = 2'b10;
        step(1'b0, 4'h0, 8'h00, "R9 tx done pin1");
        rts_ctl_en = 2'b11;
        for (int m = 0; m < 4; m++) begin
            rx_rts = {1'b0, m[0]};
            tx_done = {1'b0, m[1]};
            step(1'b0, 4'h0, 8'h00, "R10 both controls");
        end
        rts_ctl_en = '0; txd_ctl_en = '0;
        step(1'b0, 4'h0, 8'h00, "R5 plain register");
        done = 1'b1;
        #5;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule